// File: doc/BRIEF.md
# Multiband Band-Stop FIR Filter

This block strips mains hum from a slow biomedical signal. One symmetric impulse response cuts four narrow stop bands, at the 50 Hz fundamental and at 100, 150 and 200 Hz, for data sampled at 1000 samples per second. Samples are signed 10-bit words. Each one arrives with a single-cycle strobe, and the strobes come far apart in clock terms.

Each accepted sample enters a tapped delay line. A single time-shared multiply-accumulate unit then works through the taps before the next strobe. It uses the symmetry of the response to pre-add mirrored taps, so it needs one cycle per coefficient pair. The wide sum is rounded, saturated and presented as one 10-bit result with a one-cycle valid pulse. A build-time option chains two identical sections to deepen the stop bands.

The coefficients are constants derived at elaboration from the tap count. Their shape is a triangle-weighted sum of cosines at the four band centres, subtracted from a centre impulse.

Top module: `bsf_notch_top`

## Requirements
- R1: A synchronous reset clears the delay line, the accumulator, `out_data`, `out_valid` and `overrun` to zero.
- R2: A strobe (`in_valid` high) sampled while the unit is idle is accepted. It moves every stored sample one position older and puts `in_data` in the newest position, so successive outputs follow the sample order.
- R3: With TAPS odd and H = (TAPS-1)/2, each output is y = clamp(floor((sum over i of c[i]*x[n-i] + 256) / 512), -512, 511). Here x[n-i] is the sample accepted i strobes ago, and zero before reset ended.
- R4: The coefficients are fixed. Let Q(j) = round(512*cos(2*pi*j/20)), with ties away from zero. For tap n, let m = |n-H|, S = Q(m)+Q(2m)+Q(3m)+Q(4m), W = H+1-m and D = floor((H+1)^2/2). Then g = round(S*W/D), with ties away from zero. The coefficient is c[n] = 512-g when m = 0 and -g otherwise.
- R5: The response is symmetric, c[n] = c[TAPS-1-n], so a lone impulse yields an output sequence that reads the same in both directions, centred H samples after the impulse.
- R6: Results beyond the 10-bit range saturate to 511 or -512 instead of wrapping.
- R7: `out_valid` is high for exactly one cycle. It rises after the (H+1)-th rising edge that follows the edge that accepted the strobe, so the work finishes well inside 1000 cycles.
- R8: A strobe sampled while the unit is busy is dropped, and the delay line is left unchanged. It sets `overrun`, which stays set until reset.
- R9: With CASCADE = 1, the sample passes through two identical sections in series. The output is the R3 function applied twice, and it appears 2H+3 rising edges after the accepting edge.
- R10: A steady 50 Hz or 150 Hz tone of amplitude 400 comes out with a peak magnitude of at most 100 once the delay line has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | 10 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 10 | Signed filtered result, held between pulses |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The hardest behaviour to provoke from the ports is a dropped strobe. It needs a second strobe to land inside the H+1 cycle busy window. The bench must then show, through a later result, that the dropped value never entered the delay line. The bench does this directly: it raises a strobe a few cycles into a computation, then sends a normal sample and compares the output against a model history that omits the dropped value. Saturation is also hard to reach, because real signals do not drive it. The bench provokes it with a full-scale input whose signs follow the signs of the coefficients, which drives the weighted sum past both rails.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  localparam int SAMPLE_W = 10;
  localparam int COEF_W   = 10;
  localparam int FRAC_W   = 9;
  localparam int OUT_MAX  = (1 << (SAMPLE_W - 1)) - 1;
  localparam int OUT_MIN  = -(1 << (SAMPLE_W - 1));
  localparam int UNITY    = 1 << FRAC_W;
  localparam int GRID     = 20;  // band centres sit on multiples of fs/GRID

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;

  function automatic int idx_width(input int taps);
    int n;
    n = $clog2((taps - 1) / 2 + 1);
    return (n < 1) ? 1 : n;
  endfunction

  // cosine of 2*pi*j/GRID in Q9, folded onto the first quarter
  function automatic int cos_q9(input int j);
    int r;
    int q;
    int mag;
    r = j % GRID;
    if (r < 0) r = r + GRID;
    if (r > GRID / 2) r = GRID - r;
    q = (r <= GRID / 4) ? r : (GRID / 2 - r);
    case (q)
      0: mag = 512;
      1: mag = 487;
      2: mag = 414;
      3: mag = 301;
      4: mag = 158;
      default: mag = 0;
    endcase
    return (r <= GRID / 4) ? mag : -mag;
  endfunction

  function automatic coef_t tap_coef(input int n, input int taps);
    int half;
    int m;
    int s;
    int w;
    int d;
    int num;
    int g;
    half = (taps - 1) / 2;
    m = (n >= half) ? n - half : half - n;
    s = 0;
    for (int k = 1; k <= 4; k++) s = s + cos_q9(k * m);
    w = half + 1 - m;
    d = ((half + 1) * (half + 1)) / 2;
    num = s * w;
    g = (num >= 0) ? (num + d / 2) / d : -((-num + d / 2) / d);
    return (m == 0) ? coef_t'(UNITY - g) : coef_t'(-g);
  endfunction

  function automatic sample_t round_sat(input longint acc);
    longint r;
    r = (acc + longint'(UNITY / 2)) >>> FRAC_W;
    if (r > longint'(OUT_MAX)) return sample_t'(OUT_MAX);
    if (r < longint'(OUT_MIN)) return sample_t'(OUT_MIN);
    return sample_t'(r);
  endfunction

endpackage

// File: rtl/bsf_delay_line.sv
module bsf_delay_line
  import bsf_pkg::*;
#(
  parameter int TAPS = 101
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    shift_en,
  input  sample_t din,
  output sample_t taps_o [TAPS]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps_o[i] <= '0;
    end else if (shift_en) begin
      taps_o[0] <= din;
      for (int i = 1; i < TAPS; i++) taps_o[i] <= taps_o[i-1];
    end
  end

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_o[TAPS-1]) && $stable(taps_o[0]));

  p_newest_enters_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps_o[0] == $past(din));

endmodule

// File: rtl/bsf_coef_rom.sv
module bsf_coef_rom
  import bsf_pkg::*;
#(
  parameter int TAPS = 101
) (
  input  logic [idx_width(TAPS)-1:0] idx,
  output coef_t                      coef
);

  localparam int HALF = (TAPS - 1) / 2;

  coef_t tbl [HALF+1];

  for (genvar g = 0; g <= HALF; g++) begin : g_tap
    localparam coef_t CV = tap_coef(g, TAPS);
    assign tbl[g] = CV;
  end

  assign coef = (int'(idx) <= HALF) ? tbl[idx] : '0;

endmodule

// File: rtl/bsf_mac.sv
module bsf_mac
  import bsf_pkg::*;
#(
  parameter int TAPS = 101
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  coef_t                      coef,
  input  logic signed [SAMPLE_W:0]   pair,
  output logic                       busy,
  output logic [idx_width(TAPS)-1:0] idx,
  output logic                       done,
  output sample_t                    result
);

  localparam int HALF    = (TAPS - 1) / 2;
  localparam int IDX_W   = idx_width(TAPS);
  localparam int PROD_W  = COEF_W + SAMPLE_W + 1;
  localparam int ACC_RAW = PROD_W + $clog2(HALF + 1);
  localparam int ACC_W   = (ACC_RAW > 30) ? ACC_RAW : 30;

  logic signed [PROD_W-1:0] term;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_next;
  logic                     last_step;

  assign term      = coef * pair;
  assign acc_next  = acc + {{(ACC_W-PROD_W){term[PROD_W-1]}}, term};
  assign last_step = busy && (idx == IDX_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      acc    <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc_next;
        if (last_step) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= round_sat(longint'(acc_next));
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_runs_to_end_r7: assert property (@(posedge clk) disable iff (rst)
    busy && idx != IDX_W'(HALF) |=> busy && !done);

  p_result_moves_with_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

endmodule

// File: rtl/bsf_section.sv
module bsf_section
  import bsf_pkg::*;
#(
  parameter int TAPS = 101
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  sample_t in_data,
  output logic    out_valid,
  output sample_t out_data,
  output logic    overrun
);

  localparam int HALF   = (TAPS - 1) / 2;
  localparam int IDX_W  = idx_width(TAPS);
  localparam int TIDX_W = ($clog2(TAPS) < 1) ? 1 : $clog2(TAPS);

  sample_t                   taps [TAPS];
  logic                      busy;
  logic [IDX_W-1:0]          idx;
  coef_t                     coef;
  logic                      accept;
  logic                      collide;
  logic [TIDX_W-1:0]         lo_i;
  logic [TIDX_W-1:0]         hi_i;
  logic signed [SAMPLE_W:0]  a_ext;
  logic signed [SAMPLE_W:0]  b_ext;
  logic signed [SAMPLE_W:0]  pair;

  assign accept  = in_valid && !busy;
  assign collide = in_valid && busy;

  bsf_delay_line #(.TAPS(TAPS)) u_dl (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .din      (in_data),
    .taps_o   (taps)
  );

  bsf_coef_rom #(.TAPS(TAPS)) u_rom (
    .idx  (idx),
    .coef (coef)
  );

  always_comb begin
    lo_i  = TIDX_W'(idx);
    hi_i  = TIDX_W'(TAPS - 1) - lo_i;
    a_ext = {taps[lo_i][SAMPLE_W-1], taps[lo_i]};
    b_ext = (idx == IDX_W'(HALF)) ? '0 : {taps[hi_i][SAMPLE_W-1], taps[hi_i]};
    pair  = a_ext + b_ext;
  end

  bsf_mac #(.TAPS(TAPS)) u_mac (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .coef   (coef),
    .pair   (pair),
    .busy   (busy),
    .idx    (idx),
    .done   (out_valid),
    .result (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (collide) overrun <= 1'b1;
  end

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && busy |=> overrun);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

// File: rtl/bsf_notch_top.sv
module bsf_notch_top
  import bsf_pkg::*;
#(
  parameter int TAPS    = 101,
  parameter int CASCADE = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [9:0] in_data,
  output logic       out_valid,
  output logic [9:0] out_data,
  output logic       overrun
);

  localparam int NSEC = (CASCADE != 0) ? 2 : 1;

  logic [NSEC:0]   st_v;
  sample_t         st_d [NSEC+1];
  logic [NSEC-1:0] ovr;

  assign st_v[0] = in_valid;
  assign st_d[0] = sample_t'(in_data);

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    bsf_section #(.TAPS(TAPS)) u_sec (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (st_v[s]),
      .in_data   (st_d[s]),
      .out_valid (st_v[s+1]),
      .out_data  (st_d[s+1]),
      .overrun   (ovr[s])
    );
  end

  assign out_valid = st_v[NSEC];
  assign out_data  = st_d[NSEC];
  assign overrun   = |ovr;

endmodule

// File: tb/bsf_notch_top_bench.sv
`timescale 1ns/1ps
module bsf_notch_top_bench;

  localparam int TAPS = 101;
  localparam int HALF = (TAPS - 1) / 2;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              cin_valid = 1'b0;
  logic signed [9:0] in_data = '0;
  logic              out_valid, cout_valid, overrun, coverrun;
  logic signed [9:0] out_data, cout_data;

  bsf_notch_top #(.TAPS(TAPS), .CASCADE(0)) u_bsf_notch_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .overrun(overrun));

  bsf_notch_top #(.TAPS(TAPS), .CASCADE(1)) u_bsf_notch_top_cas (
    .clk(clk), .rst(rst), .in_valid(cin_valid), .in_data(in_data),
    .out_valid(cout_valid), .out_data(cout_data), .overrun(coverrun));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int coef_m [TAPS];
  int hm [TAPS];
  int hc1 [TAPS];
  int hc2 [TAPS];
  int imp [TAPS];

  function automatic int ref_cos(input int j);
    real v;
    v = 512.0 * $cos(2.0 * PI * real'(j) / 20.0);
    return int'(v);
  endfunction

  function automatic int ref_coef(input int n);
    int m, s, w, d, g;
    m = (n > HALF) ? n - HALF : HALF - n;
    s = ref_cos(m) + ref_cos(2*m) + ref_cos(3*m) + ref_cos(4*m);
    w = HALF + 1 - m;
    d = ((HALF + 1) * (HALF + 1)) / 2;
    g = int'(real'(s * w) / real'(d));
    return (m == 0) ? 512 - g : -g;
  endfunction

  function automatic int ref_filter(input int h [TAPS]);
    longint acc;
    int y;
    acc = 0;
    for (int i = 0; i < TAPS; i++) acc += longint'(coef_m[i]) * longint'(h[i]);
    y = int'($floor((real'(acc) + 256.0) / 512.0));
    if (y > 511) y = 511;
    if (y < -512) y = -512;
    return y;
  endfunction

  task automatic push(input int which, input int x);
    for (int i = TAPS - 1; i > 0; i--) begin
      case (which)
        0: hm[i] = hm[i-1];
        1: hc1[i] = hc1[i-1];
        default: hc2[i] = hc2[i-1];
      endcase
    end
    case (which)
      0: hm[0] = x;
      1: hc1[0] = x;
      default: hc2[0] = x;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    cin_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      hm[i] = 0; hc1[i] = 0; hc2[i] = 0;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 10'sd0, "R1 out_data", int'(out_data), 0);
    check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
  endtask

  task automatic send_main(input int x, input string tag, output int y);
    int exp, stamp;
    bit got;
    push(0, x);
    exp = ref_filter(hm);
    @(negedge clk);
    in_data = 10'(x);
    in_valid = 1'b1;
    stamp = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    got = 0;
    y = 0;
    repeat (HALF + 8) begin
      @(negedge clk);
      if (!got && out_valid) begin
        got = 1;
        y = int'(out_data);
        check(cyc - stamp == HALF + 2, "R7 latency", cyc - stamp, HALF + 2);
        check(y == exp, tag, y, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 pulse width", int'(out_valid), 0);
      end
    end
    if (!got) check(1'b0, "R7 no result", 0, 1);
  endtask

  task automatic send_cas(input int x);
    int e1, exp, stamp;
    bit got;
    push(1, x);
    e1 = ref_filter(hc1);
    push(2, e1);
    exp = ref_filter(hc2);
    @(negedge clk);
    in_data = 10'(x);
    cin_valid = 1'b1;
    stamp = cyc;
    @(negedge clk);
    cin_valid = 1'b0;
    got = 0;
    repeat (2 * HALF + 12) begin
      @(negedge clk);
      if (!got && cout_valid) begin
        got = 1;
        check(cyc - stamp == 2 * HALF + 4, "R9 latency", cyc - stamp, 2 * HALF + 4);
        check(int'(cout_data) == exp, "R9 data", int'(cout_data), exp);
      end
    end
    if (!got) check(1'b0, "R9 no result", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int y, exp, x, stamp, pk;
    bit got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < TAPS; i++) coef_m[i] = ref_coef(i);

    // R1 reset, R2/R4/R5 impulse response
    do_reset();
    send_main(511, "R2 impulse order", imp[0]);
    for (int i = 1; i < TAPS; i++) send_main(0, "R2 impulse order", imp[i]);
    for (int i = 0; i < TAPS; i++) begin
      exp = int'($floor((real'(coef_m[i]) * 511.0 + 256.0) / 512.0));
      check(imp[i] == exp, "R4 coefficient", imp[i], exp);
    end
    for (int i = 0; i < HALF; i++)
      check(imp[i] == imp[TAPS-1-i], "R5 symmetry", imp[i], imp[TAPS-1-i]);
    check(imp[HALF] > imp[HALF-1], "R5 centre peak", imp[HALF], imp[HALF-1]);

    // R3 random stream mixed with rails
    for (int i = 0; i < 160; i++) begin
      if (i % 37 == 5)       x = 511;
      else if (i % 37 == 6)  x = -512;
      else                   x = int'($urandom_range(1023)) - 512;
      send_main(x, "R3 random", y);
    end

    // R8 strobe during busy is dropped
    push(0, 77);
    exp = ref_filter(hm);
    @(negedge clk);
    in_data = 10'sd77; in_valid = 1'b1; stamp = cyc;
    got = 0;
    for (int t = 1; t <= HALF + 8; t++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (t == 10) begin in_data = 10'sd99; in_valid = 1'b1; end
      if (!got && out_valid) begin
        got = 1;
        check(int'(out_data) == exp, "R8 first result", int'(out_data), exp);
        check(cyc - stamp == HALF + 2, "R7 latency", cyc - stamp, HALF + 2);
      end
    end
    in_valid = 1'b0;
    check(got, "R8 first result present", int'(got), 1);
    check(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
    send_main(5, "R8 dropped sample absent", y);
    send_main(-3, "R8 dropped sample absent", y);
    check(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);

    // R1 reset clears overrun and history
    do_reset();
    send_main(100, "R1 history cleared", y);

    // R6 saturation, both rails
    do_reset();
    for (int j = 0; j < TAPS; j++) send_main(coef_m[j] >= 0 ? 511 : -512, "R6 model", y);
    check(y == 511, "R6 positive rail", y, 511);
    do_reset();
    for (int j = 0; j < TAPS; j++) send_main(coef_m[j] >= 0 ? -512 : 511, "R6 model", y);
    check(y == -512, "R6 negative rail", y, -512);

    // R10 tones inside stop bands
    for (int f = 1; f <= 3; f += 2) begin
      do_reset();
      pk = 0;
      for (int j = 0; j < TAPS + 40; j++) begin
        x = int'(400.0 * $sin(2.0 * PI * real'(f * j) / 20.0));
        send_main(x, "R10 model", y);
        if (j >= TAPS && (y > pk || -y > pk)) pk = (y < 0) ? -y : y;
      end
      check(pk <= 100, "R10 stop band attenuation", pk, 100);
    end

    // R9 cascade
    do_reset();
    send_cas(400);
    for (int i = 0; i < 70; i++) send_cas(int'($urandom_range(1023)) - 512);
    check(coverrun == 1'b0, "R9 no overrun in chain", int'(coverrun), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule